// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Daisy Unit

This block arbitrates the eight interrupt sources of a two-channel serial controller. Each channel contributes four source types (transmit, external status, receive, error). Every source owns a pending flag and an in-service flag. The block raises a request to the processor, answers an acknowledge with an 8-bit vector, and ends service on a return-from-interrupt strobe. It also sits in a priority daisy chain through an enable input and an enable output.

The source index is the type code plus 4 for channel A, or plus 0 for channel B. The vector returned on acknowledge is the programmed base plus twice that index. Priority is fixed and interleaved by type within a channel, with channel A above channel B. A source in service masks itself and every source below it from the request output.

Top module: `irq_daisy_arb`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0, and `ieo_o` equals `ien_i`.
- R2: The type codes are transmit 0, status 1, receive 2 and error 3. Bit k of `set_i`/`clr_i` is source index k, where k = type + 4 for channel A and k = type for channel B. An acknowledge that grants source k loads `vec_o` with `base_vec_i + 2*k` (mod 256).
- R3: An acknowledge grants the highest-priority pending source. The order from highest to lowest is: A receive (6), A transmit (4), A status (5), A error (7), B receive (2), B transmit (0), B status (1), B error (3).
- R4: A granted source loses its pending flag and enters service.
- R5: An acknowledge with no source pending loads `vec_o` with `base_vec_i` unchanged.
- R6: `irq_o` is high when `ien_i` is high and some source is pending with no in-service source at or above its priority. The scan stops at the first in-service source, so that source and all lower ones are masked.
- R7: `reti_i` clears the in-service flag of the highest-priority in-service source only.
- R8: `ch_reset_i[1]` clears the pending flags of indices 4..7 (channel A). `ch_reset_i[0]` clears the pending flags of indices 0..3 (channel B).
- R9: A set of a source in the same cycle as any clear of that source wins. The clear may come from `clr_i`, a channel reset or a grant.
- R10: `ieo_o` is low whenever `ien_i` is low or any source is in service, and high otherwise. `irq_o` is low while `ien_i` is low.
- R11: `vec_o` is registered. It shows the new vector in the cycle after `iack_i` and holds it until the next acknowledge, whatever `base_vec_i` does.
- R12: A `clr_i` bit without a matching set clears that source's pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 8 | Per-source set strobes, one per index |
| clr_i | input | 8 | Per-source clear strobes, one per index |
| ch_reset_i | input | 2 | Channel reset; bit 1 is channel A, bit 0 is channel B |
| base_vec_i | input | 8 | Base interrupt vector |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ien_i | input | 1 | Daisy-chain enable in |
| ieo_o | output | 1 | Daisy-chain enable out |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector captured on acknowledge |

## Verification
Flag updates caused by set, clear, channel reset, acknowledge or return land on the clock edge that samples the strobe. `irq_o` and `ieo_o` follow combinationally from those flags and `ien_i`, so the bench drives each strobe for one cycle and checks these outputs at the falling edge just after that clock edge. `vec_o` is due on that same edge. The bench also checks it after several more cycles with a changed base, to show it holds. Every nonzero source mask is set and then drained by nine acknowledges and nine returns, against a bench model of the flags that is updated per operation.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
  localparam int TYPES_PER_CH = 4;

  typedef enum logic [1:0] {
    SRC_TX   = 2'd0,
    SRC_STAT = 2'd1,
    SRC_RX   = 2'd2,
    SRC_ERR  = 2'd3
  } src_type_e;

  // rank 0 = highest priority; first channel rank group is the highest index group
  function automatic int rank_to_idx(input int rank, input int num_ch);
    int grp;
    int pos;
    src_type_e t;
    grp = rank / TYPES_PER_CH;
    pos = rank % TYPES_PER_CH;
    case (pos)
      0:       t = SRC_RX;
      1:       t = SRC_TX;
      2:       t = SRC_STAT;
      default: t = SRC_ERR;
    endcase
    return (num_ch - 1 - grp) * TYPES_PER_CH + int'(t);
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic grant_i,
  input  logic ret_i,
  output logic pend_o,
  output logic insvc_o
);
  logic pend_q, insvc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      pend_q  <= set_i | (pend_q & ~clr_i & ~grant_i);
      insvc_q <= grant_i | (insvc_q & ~ret_i);
    end
  end

  assign pend_o  = pend_q;
  assign insvc_o = insvc_q;
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int NUM_CH = 2,
  localparam int N     = NUM_CH * irq_daisy_pkg::TYPES_PER_CH,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     insvc_i,
  output logic             req_o,
  output logic             any_pend_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic [N-1:0]     grant_oh_o,
  output logic [N-1:0]     ret_oh_o
);
  import irq_daisy_pkg::*;

  logic [N-1:0] rank_pend, rank_insvc, rank_grant, rank_ret;

  for (genvar r = 0; r < N; r++) begin : g_rank
    localparam int IDX = rank_to_idx(r, NUM_CH);
    assign rank_pend[r]    = pend_i[IDX];
    assign rank_insvc[r]   = insvc_i[IDX];
    assign grant_oh_o[IDX] = rank_grant[r];
    assign ret_oh_o[IDX]   = rank_ret[r];
  end

  always_comb begin
    logic blocked, found_g, found_r;
    req_o       = 1'b0;
    grant_idx_o = '0;
    rank_grant  = '0;
    rank_ret    = '0;
    blocked     = 1'b0;
    found_g     = 1'b0;
    found_r     = 1'b0;
    for (int r = 0; r < N; r++) begin
      if (!blocked) begin
        if (rank_insvc[r])     blocked = 1'b1;
        else if (rank_pend[r]) req_o   = 1'b1;
      end
      if (!found_g && rank_pend[r]) begin
        found_g       = 1'b1;
        rank_grant[r] = 1'b1;
        grant_idx_o   = IDX_W'(rank_to_idx(r, NUM_CH));
      end
      if (!found_r && rank_insvc[r]) begin
        found_r     = 1'b1;
        rank_ret[r] = 1'b1;
      end
    end
    any_pend_o = found_g;
  end
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int VEC_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iack_i,
  input  logic             any_pend_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VEC_W-1:0] base_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (iack_i) vec_q <= any_pend_i ? base_i + (VEC_W'(idx_i) << 1) : base_i;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/irq_daisy_arb.sv
module irq_daisy_arb #(
  parameter int NUM_CH = 2,
  parameter int VEC_W  = 8,
  localparam int TPC   = irq_daisy_pkg::TYPES_PER_CH,
  localparam int N     = NUM_CH * TPC,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      set_i,
  input  logic [N-1:0]      clr_i,
  input  logic [NUM_CH-1:0] ch_reset_i,
  input  logic [VEC_W-1:0]  base_vec_i,
  input  logic              iack_i,
  input  logic              reti_i,
  input  logic              ien_i,
  output logic              ieo_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N-1:0]     pend_q, insvc_q, clr_eff, grant_oh, ret_oh;
  logic [IDX_W-1:0] grant_idx;
  logic             req, any_pend;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign clr_eff[c*TPC +: TPC] = clr_i[c*TPC +: TPC] | {TPC{ch_reset_i[c]}};
  end

  for (genvar k = 0; k < N; k++) begin : g_src
    irq_src_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_i[k]),
      .clr_i   (clr_eff[k]),
      .grant_i (iack_i & grant_oh[k]),
      .ret_i   (reti_i & ret_oh[k]),
      .pend_o  (pend_q[k]),
      .insvc_o (insvc_q[k])
    );
  end

  irq_prio_scan #(.NUM_CH(NUM_CH)) u_scan (
    .pend_i      (pend_q),
    .insvc_i     (insvc_q),
    .req_o       (req),
    .any_pend_o  (any_pend),
    .grant_idx_o (grant_idx),
    .grant_oh_o  (grant_oh),
    .ret_oh_o    (ret_oh)
  );

  irq_vec_reg #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iack_i     (iack_i),
    .any_pend_i (any_pend),
    .idx_i      (grant_idx),
    .base_i     (base_vec_i),
    .vec_o      (vec_o)
  );

  assign irq_o = ien_i & req;
  assign ieo_o = ien_i & ~(|insvc_q);
endmodule

// File: rtl/irq_daisy_arb_chk.sv
module irq_daisy_arb_chk #(
  parameter int N     = 8,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     set_i,
  input logic [N-1:0]     pend_q,
  input logic [N-1:0]     insvc_q,
  input logic [VEC_W-1:0] base_vec_i,
  input logic             iack_i,
  input logic             reti_i,
  input logic             ien_i,
  input logic             ieo_o,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o
);
  // R10
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |-> (!irq_o && !ieo_o));

  // R10
  ieo_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|insvc_q) |-> !ieo_o);

  // R5
  empty_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && pend_q == '0) |=> vec_o == $past(base_vec_i));

  // R2
  vec_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i |=> vec_o[0] == $past(base_vec_i[0]));

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (pend_q & $past(set_i)) == $past(set_i));

  // R7
  reti_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !iack_i && insvc_q != '0) |=> $countones(insvc_q) == $past($countones(insvc_q)) - 1);

  // R11
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |=> $stable(vec_o));
endmodule

bind irq_daisy_arb irq_daisy_arb_chk #(.N(N), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .set_i      (set_i),
  .pend_q     (pend_q),
  .insvc_q    (insvc_q),
  .base_vec_i (base_vec_i),
  .iack_i     (iack_i),
  .reti_i     (reti_i),
  .ien_i      (ien_i),
  .ieo_o      (ieo_o),
  .irq_o      (irq_o),
  .vec_o      (vec_o)
);

// File: tb/irq_daisy_arb_tb_top.sv
module irq_daisy_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] set_s = '0, clr_s = '0, base = '0;
  logic [1:0] chr = '0;
  logic       iack = 1'b0, reti = 1'b0, ien = 1'b1;
  logic       ieo, irq;
  logic [7:0] vec;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit [7:0] mp = '0, mi = '0;
  int exp_vec = 0;

  always #4 clk = ~clk;

  irq_daisy_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .clr_i(clr_s), .ch_reset_i(chr),
    .base_vec_i(base), .iack_i(iack), .reti_i(reti), .ien_i(ien),
    .ieo_o(ieo), .irq_o(irq), .vec_o(vec)
  );

  function automatic int rank_idx(input int r);
    int p, t;
    p = r % 4;
    t = (p == 0) ? 2 : (p == 1) ? 0 : (p == 2) ? 1 : 3;
    return (1 - r / 4) * 4 + t;
  endfunction

  function automatic int top_of(input bit [7:0] v);
    for (int r = 0; r < 8; r++) if (v[rank_idx(r)]) return rank_idx(r);
    return -1;
  endfunction

  function automatic bit m_req();
    for (int r = 0; r < 8; r++) begin
      if (mi[rank_idx(r)]) return 1'b0;
      if (mp[rank_idx(r)]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle strobe, model update, checks at falling edge after the capturing edge
  task automatic step(input bit [7:0] s, input bit [7:0] c, input bit [1:0] cr,
                      input bit a, input bit rt);
    int g, q;
    bit [7:0] gm, rm, crm;
    @(negedge clk);
    set_s = s; clr_s = c; chr = cr; iack = a; reti = rt;
    @(negedge clk);
    set_s = '0; clr_s = '0; chr = '0; iack = 1'b0; reti = 1'b0;
    g = top_of(mp);
    q = top_of(mi);
    gm  = (a && g >= 0) ? 8'(1 << g) : 8'h00;
    rm  = (rt && q >= 0) ? 8'(1 << q) : 8'h00;
    crm = {{4{cr[1]}}, {4{cr[0]}}};
    if (a) exp_vec = (g < 0) ? int'(base) : int'(8'(base + 8'(2 * g)));
    mp = s | (mp & ~c & ~crm & ~gm);
    mi = gm | (mi & ~rm);
    chk("R6 irq", irq, ien & m_req());
    chk("R10 ieo", ieo, ien & (mi == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 vec", vec, 0);
    chk("R1 ieo", ieo, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7: sweep every nonzero source mask
    for (int m = 1; m < 256; m++) begin
      base = 8'(m * 37);
      step(8'(m), 8'h00, 2'b00, 1'b0, 1'b0);
      for (int k = 0; k < 9; k++) begin
        step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
        chk("R3 vec", vec, exp_vec);
      end
      chk("R4 pend drained", int'(mp), 0);
      for (int k = 0; k < 9; k++) step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
      chk("R7 all returned", ieo, 1);
    end

    // R2 single-source index check: A error (7), B transmit (0)
    base = 8'h40;
    step(8'h80, 8'h00, 2'b00, 1'b0, 1'b0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R2 A error vec", vec, 8'h4e);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    step(8'h01, 8'h00, 2'b00, 1'b0, 1'b0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R2 B tx vec", vec, 8'h40);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);

    // R6 higher source raises irq while lower in service
    step(8'h04, 8'h00, 2'b00, 1'b0, 1'b0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    step(8'h08, 8'h00, 2'b00, 1'b0, 1'b0);
    chk("R6 lower masked", irq, 0);
    step(8'h40, 8'h00, 2'b00, 1'b0, 1'b0);
    chk("R6 higher raises", irq, 1);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R3 A rx over B err", vec, 8'h4c);
    // R7 reti ends only A rx; B rx still in service, B err still masked
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    chk("R7 still masked", irq, 0);
    chk("R7 ieo low", ieo, 0);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    chk("R7 unmasked", irq, 1);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R3 B err vec", vec, 8'h46);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);

    // R8 channel resets
    step(8'hff, 8'h00, 2'b00, 1'b0, 1'b0);
    step(8'h00, 8'h00, 2'b10, 1'b0, 1'b0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R8 A cleared", vec, 8'h44);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    step(8'h00, 8'h00, 2'b01, 1'b0, 1'b0);
    chk("R8 B cleared irq", irq, 0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R8 B cleared vec", vec, 8'h40);

    // R9 set beats clr and channel reset
    step(8'h20, 8'h20, 2'b00, 1'b0, 1'b0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R9 set over clr", vec, 8'h4a);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    step(8'h02, 8'h00, 2'b01, 1'b0, 1'b0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R9 set over ch reset", vec, 8'h42);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    // R9 set beats grant of same source
    step(8'h10, 8'h00, 2'b00, 1'b0, 1'b0);
    step(8'h10, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R9 set over grant", int'(mp), 8'h10);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R9 re-granted", vec, 8'h48);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);

    // R12 clear alone
    step(8'h08, 8'h00, 2'b00, 1'b0, 1'b0);
    step(8'h00, 8'h08, 2'b00, 1'b0, 1'b0);
    chk("R12 irq", irq, 0);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R12 vec", vec, 8'h40);

    // R10 enable-in gating
    ien = 1'b0;
    step(8'h01, 8'h00, 2'b00, 1'b0, 1'b0);
    chk("R10 irq gated", irq, 0);
    chk("R10 ieo gated", ieo, 0);
    ien = 1'b1;
    @(negedge clk);
    chk("R10 irq enabled", irq, 1);
    chk("R10 ieo enabled", ieo, 1);

    // R11 vector hold across base change
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R11 vec next cycle", vec, 8'h40);
    base = 8'h90;
    repeat (4) @(negedge clk);
    chk("R11 vec held", vec, 8'h40);
    step(8'h00, 8'h00, 2'b00, 1'b0, 1'b1);
    step(8'h00, 8'h00, 2'b00, 1'b1, 1'b0);
    chk("R11 vec new base", vec, 8'h90);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule